// File: doc/BRIEF.md
# AC'97 codec register access engine

This block lets a host read and write the control registers of an external AC'97 codec through the two link slots that carry register traffic: the command slot (slot 1) and the data slot (slot 2). A third path, the auxiliary slot (slot 12), is carried in the same way. The host sees a small register file on a simple bus. It holds a control word, a slot flag word, three transmit holding registers and three receive registers. On the link side the block hands 20-bit slot payloads to a frame serializer through a valid/ready handshake. It takes returned payloads from the serializer as single-cycle strobes tagged with a slot code.

To write a codec register, software loads the data-slot register with the 16-bit value placed at bits 19:4. It then loads the command-slot register with the 7-bit index placed at bits 18:12. Writing the command slot launches the pair, and the command word always goes out before the data word. A read request is a command word with bit 19 set and no data word. The codec's reply comes back as a command-slot payload that echoes the index at bits 18:12, followed by a data-slot payload that carries the value at bits 19:4. Software polls the flag word to follow the exchange.

Bus word offsets: 0 control, 1 flags, 2 command TX, 3 data TX, 4 aux TX, 5 command RX, 6 data RX, 7 aux RX. Transmit and receive registers read back as their 20-bit payload in bits 19:0, with the upper bits zero. Link slot codes are 0 for the command slot, 1 for the data slot and 2 for the aux slot.

Top module: `codec_reg_engine`

## Requirements
- R1: After reset the flag word reads 0xA80 and no payload is offered. Flag bits are: 0 cmd RX busy, 1 cmd TX busy, 2 data RX busy, 3 data TX busy, 4 aux RX busy, 5 aux TX busy, 6 cmd RX valid, 7 cmd TX empty, 8 data RX valid, 9 data TX empty, 10 aux RX valid, 11 aux TX empty.
- R2: A write to the command TX register launches a transfer. The command payload (slot code 0) is offered first. If the data TX register is loaded, its payload (slot code 1) follows directly. Each payload is carried unchanged as 20 bits.
- R3: A command word with bit 19 set and no loaded data word goes out alone. When it is accepted, the cmd RX busy flag and the data RX busy flag are set, each only if its receive enable is on.
- R4: A TX register write sets that slot's TX busy flag and clears its TX empty flag. Both return when the serializer accepts that slot's payload.
- R5: Control bits are 0 interface enable, 3/4 cmd RX/TX enable, 5/6 data RX/TX enable and 7/8 aux RX/TX enable. A loaded slot is not offered while its TX enable is low. A command launch also waits while the data slot is loaded and the data TX enable is low.
- R6: A write to a TX register whose busy flag is set is ignored.
- R7: The codec number sits at control bits 12:10, and its low two bits drive the link codec select. While the number is 4 or more, no transfer is launched.
- R8: Once offered, a payload and its slot code hold steady until the serializer accepts it.
- R9: A returned payload is stored in a slot's RX register only while that slot's RX enable is on. Storing it sets the slot's RX valid flag and clears its RX busy flag. With the enable off, the register and the flags are unchanged.
- R10: Reading an RX register clears its valid flag. A capture in the same cycle takes precedence and leaves the flag set.
- R11: While interface enable is low, every slot register and flag is held at its reset state, and pending transmit data is discarded. The control register stays writable.
- R12: An aux slot payload is sent alone. When a command launch is ready in the same cycle, the command pair goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_rd | input | 1 | Host register read strobe (clears RX valid on RX offsets) |
| bus_addr | input | ADDR_W | Host word offset |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data for the addressed word |
| link_tx_valid | output | 1 | Payload offered to the serializer |
| link_tx_ready | input | 1 | Serializer takes the offered payload |
| link_tx_slot | output | 2 | Slot code of the offered payload |
| link_tx_data | output | PAY_W | Offered slot payload |
| link_tx_codec | output | 2 | Codec select |
| link_rx_valid | input | 1 | Returned payload strobe |
| link_rx_slot | input | 2 | Slot code of returned payload |
| link_rx_data | input | PAY_W | Returned slot payload |

## Verification
The hardest situations to reach from the ports are the ones where two things meet in one cycle. One is a returned payload arriving while the host reads the same RX register. Another is a command launch that is legal on its own but is blocked because the data slot is loaded with its transmit path disabled. The stimulus reaches them by programming control words that switch off single enables, loading slots in the blocked state and then re-enabling them all at once. It also drives the read strobe and the receive strobe together in one cycle. A stalling ready pattern keeps every offered payload waiting for several cycles, so that the hold rule and the slot ordering are exercised under back-pressure.

// File: rtl/crx_pkg.sv
package crx_pkg;

    localparam int SLOTS      = 3;
    localparam int CODEC_W    = 3;
    localparam int MAX_CODECS = 4;
    localparam int FLAG_W     = 4 * SLOTS;

    // host word offsets
    localparam int A_CTRL   = 0;
    localparam int A_FLAGS  = 1;
    localparam int A_TX_BASE = 2;
    localparam int A_RX_BASE = A_TX_BASE + SLOTS;

    typedef enum logic [1:0] {
        SLOT_CMD = 2'd0,
        SLOT_VAL = 2'd1,
        SLOT_AUX = 2'd2
    } slot_e;

    typedef struct packed {
        logic [CODEC_W-1:0] codec;
        logic               rsvd_hi;
        logic               aux_tx;
        logic               aux_rx;
        logic               val_tx;
        logic               val_rx;
        logic               cmd_tx;
        logic               cmd_rx;
        logic [1:0]         rsvd_lo;
        logic               iface;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // empty flags set, everything else clear
    localparam logic [FLAG_W-1:0] FLAGS_IDLE = 12'hA80;

    function automatic logic [FLAG_W-1:0] pack_flags(
        input logic [SLOTS-1:0] txb,
        input logic [SLOTS-1:0] rxb,
        input logic [SLOTS-1:0] rxv
    );
        logic [FLAG_W-1:0] f;
        f = '0;
        for (int s = 0; s < SLOTS; s++) begin
            f[2*s]             = rxb[s];
            f[2*s+1]           = txb[s];
            f[2*SLOTS+2*s]     = rxv[s];
            f[2*SLOTS+2*s+1]   = !txb[s];
        end
        return f;
    endfunction

endpackage

// File: rtl/crx_txseq.sv
module crx_txseq
    import crx_pkg::*;
#(
    parameter int PAY_W = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic [SLOTS-1:0]            wr_stb,
    input  logic [PAY_W-1:0]            wr_data,
    input  logic [SLOTS-1:0]            tx_en,
    input  logic                        codec_ok,
    input  logic                        link_ready,
    output logic                        link_valid,
    output slot_e                       link_slot,
    output logic [PAY_W-1:0]            link_data,
    output logic [SLOTS-1:0]            busy,
    output logic [SLOTS-1:0][PAY_W-1:0] held,
    output logic                        rd_launch
);

    localparam int RD_BIT = PAY_W - 1;

    typedef enum logic [1:0] {SQ_IDLE, SQ_CMD, SQ_VAL, SQ_AUX} sq_e;

    sq_e state_q, state_d;
    logic accept, pair_go, aux_go;
    logic [SLOTS-1:0] done;

    always_comb begin
        case (state_q)
            SQ_VAL:  link_slot = SLOT_VAL;
            SQ_AUX:  link_slot = SLOT_AUX;
            default: link_slot = SLOT_CMD;
        endcase
    end

    assign link_valid = (state_q != SQ_IDLE) && !clear;
    assign link_data  = held[link_slot];
    assign accept     = link_valid && link_ready;
    assign rd_launch  = accept && (state_q == SQ_CMD) && held[SLOT_CMD][RD_BIT];

    // a command waits for a loaded but disabled data slot
    assign pair_go = busy[SLOT_CMD] && tx_en[SLOT_CMD] && codec_ok &&
                     (!busy[SLOT_VAL] || tx_en[SLOT_VAL]);
    assign aux_go  = busy[SLOT_AUX] && tx_en[SLOT_AUX] && codec_ok;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE: begin
                if (pair_go)     state_d = SQ_CMD;
                else if (aux_go) state_d = SQ_AUX;
            end
            SQ_CMD:  if (accept) state_d = busy[SLOT_VAL] ? SQ_VAL : SQ_IDLE;
            default: if (accept) state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) state_q <= SQ_IDLE;
        else              state_q <= state_d;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_hold
        assign done[g] = accept && (link_slot == slot_e'(g));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                held[g] <= '0;
                busy[g] <= 1'b0;
            end else if (wr_stb[g]) begin
                held[g] <= wr_data;
                busy[g] <= 1'b1;
            end else if (done[g]) begin
                busy[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crx_rxcap.sv
module crx_rxcap
    import crx_pkg::*;
#(
    parameter int PAY_W = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic [SLOTS-1:0]            cap,
    input  logic [PAY_W-1:0]            cap_data,
    input  logic [SLOTS-1:0]            rd_clr,
    input  logic [SLOTS-1:0]            arm,
    output logic [SLOTS-1:0][PAY_W-1:0] data,
    output logic [SLOTS-1:0]            valid,
    output logic [SLOTS-1:0]            rbusy
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_rx
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                data[g]  <= '0;
                valid[g] <= 1'b0;
                rbusy[g] <= 1'b0;
            end else begin
                if (cap[g]) begin
                    data[g]  <= cap_data;
                    valid[g] <= 1'b1;
                end else if (rd_clr[g]) begin
                    valid[g] <= 1'b0;
                end
                // a fresh request outranks the reply that closes the old one
                if (arm[g])     rbusy[g] <= 1'b1;
                else if (cap[g]) rbusy[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/codec_reg_engine.sv
module codec_reg_engine
    import crx_pkg::*;
#(
    parameter int PAY_W  = 20,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              link_tx_valid,
    input  logic              link_tx_ready,
    output logic [1:0]        link_tx_slot,
    output logic [PAY_W-1:0]  link_tx_data,
    output logic [1:0]        link_tx_codec,
    input  logic              link_rx_valid,
    input  logic [1:0]        link_rx_slot,
    input  logic [PAY_W-1:0]  link_rx_data
);

    ctrl_t ctrl_q;
    logic iface_on, codec_ok, rd_launch;
    logic [SLOTS-1:0] tx_en, rx_en, wr_stb, cap, rd_clr, arm;
    logic [SLOTS-1:0] tx_busy, rx_valid, rx_busy;
    logic [SLOTS-1:0][PAY_W-1:0] tx_held, rx_held;
    logic [FLAG_W-1:0] slot_flags;
    slot_e tx_slot_e;
    logic unused_wbits;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (bus_wr && int'(bus_addr) == A_CTRL)
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    assign iface_on      = ctrl_q.iface;
    assign codec_ok      = int'(ctrl_q.codec) < MAX_CODECS;
    assign link_tx_codec = ctrl_q.codec[1:0];
    assign tx_en = {ctrl_q.aux_tx, ctrl_q.val_tx, ctrl_q.cmd_tx};
    assign rx_en = {ctrl_q.aux_rx, ctrl_q.val_rx, ctrl_q.cmd_rx};

    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        assign wr_stb[g] = bus_wr && iface_on && !tx_busy[g] &&
                           int'(bus_addr) == A_TX_BASE + g;
        assign rd_clr[g] = bus_rd && int'(bus_addr) == A_RX_BASE + g;
        assign cap[g]    = link_rx_valid && rx_en[g] &&
                           int'(link_rx_slot) == g;
    end

    // a read request expects replies in the command and data slots only
    assign arm = {1'b0, rd_launch && rx_en[SLOT_VAL], rd_launch && rx_en[SLOT_CMD]};

    crx_txseq #(.PAY_W(PAY_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .clear      (!iface_on),
        .wr_stb     (wr_stb),
        .wr_data    (bus_wdata[PAY_W-1:0]),
        .tx_en      (tx_en),
        .codec_ok   (codec_ok),
        .link_ready (link_tx_ready),
        .link_valid (link_tx_valid),
        .link_slot  (tx_slot_e),
        .link_data  (link_tx_data),
        .busy       (tx_busy),
        .held       (tx_held),
        .rd_launch  (rd_launch)
    );

    assign link_tx_slot = tx_slot_e;

    crx_rxcap #(.PAY_W(PAY_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .clear    (!iface_on),
        .cap      (cap),
        .cap_data (link_rx_data),
        .rd_clr   (rd_clr),
        .arm      (arm),
        .data     (rx_held),
        .valid    (rx_valid),
        .rbusy    (rx_busy)
    );

    assign slot_flags = pack_flags(tx_busy, rx_busy, rx_valid);

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == A_CTRL)
            bus_rdata = DATA_W'(ctrl_q);
        else if (int'(bus_addr) == A_FLAGS)
            bus_rdata = DATA_W'(slot_flags);
        else
            for (int s = 0; s < SLOTS; s++) begin
                if (int'(bus_addr) == A_TX_BASE + s) bus_rdata = DATA_W'(tx_held[s]);
                if (int'(bus_addr) == A_RX_BASE + s) bus_rdata = DATA_W'(rx_held[s]);
            end
    end

    assign unused_wbits = ^bus_wdata[DATA_W-1:PAY_W];

endmodule

// File: rtl/crx_checker.sv
module crx_checker
    import crx_pkg::*;
#(
    parameter int PAY_W  = 20,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              iface_on,
    input logic              codec_ok,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [1:0]        tx_slot,
    input logic [PAY_W-1:0]  tx_data,
    input logic [FLAG_W-1:0] flags,
    input logic              rx_valid,
    input logic [1:0]        rx_slot,
    input logic              cmd_rx_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr
);

    // R8: an offered payload waits unchanged for acceptance
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        iface_on && $past(tx_valid && !tx_ready)
        |-> tx_valid && $stable(tx_data) && $stable(tx_slot));

    // R2: a data-slot payload only ever follows the command or itself
    p_order_r2: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_slot == 2'd1
        |-> $past(tx_valid) && $past(tx_slot) != 2'd2);

    // R7: no launch under an out-of-range codec number
    p_codec_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(codec_ok));

    // R4: a command write into an idle slot raises its busy flag
    p_busy_r4: assert property (@(posedge clk) disable iff (rst)
        iface_on && bus_wr && int'(bus_addr) == A_TX_BASE && !flags[1]
        |=> flags[1] && !flags[7]);

    // R9: an enabled command-slot capture raises the valid flag
    p_capture_r9: assert property (@(posedge clk) disable iff (rst)
        iface_on && cmd_rx_en && rx_valid && rx_slot == 2'd0
        |=> flags[6]);

    // R11: interface off returns every flag to idle
    p_off_r11: assert property (@(posedge clk) disable iff (rst)
        !iface_on |=> flags == FLAGS_IDLE);

endmodule

bind codec_reg_engine crx_checker #(.PAY_W(PAY_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iface_on  (iface_on),
    .codec_ok  (codec_ok),
    .tx_valid  (link_tx_valid),
    .tx_ready  (link_tx_ready),
    .tx_slot   (link_tx_slot),
    .tx_data   (link_tx_data),
    .flags     (slot_flags),
    .rx_valid  (link_rx_valid),
    .rx_slot   (link_rx_slot),
    .cmd_rx_en (ctrl_q.cmd_rx),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr)
);

// File: tb/codec_reg_engine_tb.sv
module codec_reg_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PAY_W = 20;
    localparam logic [31:0] CTRL_ALL = 32'h5F9;

    logic clk, rst;
    logic bus_wr, bus_rd;
    logic [2:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic tx_valid, tx_ready;
    logic [1:0] tx_slot, tx_codec;
    logic [PAY_W-1:0] tx_data;
    logic rx_valid;
    logic [1:0] rx_slot;
    logic [PAY_W-1:0] rx_data;

    int errs = 0;
    int n_chk = 0;
    int cyc = 0;
    bit stall = 0;
    logic [21:0] acc_q[$];

    // reference model state
    logic [12:0] m_ctrl;
    logic [PAY_W-1:0] m_tx[3];
    logic [PAY_W-1:0] m_rx[3];
    bit m_busy[3], m_rxv[3], m_rxb[3];
    int m_ph;

    codec_reg_engine u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .link_tx_valid(tx_valid), .link_tx_ready(tx_ready),
        .link_tx_slot(tx_slot), .link_tx_data(tx_data),
        .link_tx_codec(tx_codec), .link_rx_valid(rx_valid),
        .link_rx_slot(rx_slot), .link_rx_data(rx_data)
    );

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_flags();
        logic [31:0] f = 0;
        for (int s = 0; s < 3; s++) begin
            f[2*s] = m_rxb[s];
            f[2*s+1] = m_busy[s];
            f[6+2*s] = m_rxv[s];
            f[7+2*s] = !m_busy[s];
        end
        return f;
    endfunction

    // ready pattern: stalls two of every three cycles when enabled
    always @(posedge clk) begin
        #1;
        cyc++;
        tx_ready = stall ? (cyc % 3 == 0) : 1'b1;
    end

    // reference model, updated at each edge from pre-edge values
    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_ph = 0;
            for (int s = 0; s < 3; s++) begin
                m_tx[s] = 0; m_rx[s] = 0; m_busy[s] = 0; m_rxv[s] = 0; m_rxb[s] = 0;
            end
        end else begin
            logic [12:0] c;
            bit ob[3];
            bit acc, ok, launch;
            c = m_ctrl;
            for (int s = 0; s < 3; s++) ob[s] = m_busy[s];
            acc = (m_ph != 0) && c[0] && tx_ready;
            launch = 0;
            if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata[12:0];
            if (!c[0]) begin
                m_ph = 0;
                for (int s = 0; s < 3; s++) begin
                    m_tx[s] = 0; m_rx[s] = 0; m_busy[s] = 0; m_rxv[s] = 0; m_rxb[s] = 0;
                end
            end else begin
                ok = (c[12:10] < 4);
                case (m_ph)
                    0: if (ob[0] && c[4] && (!ob[1] || c[6]) && ok) m_ph = 1;
                       else if (ob[2] && c[8] && ok) m_ph = 3;
                    1: if (acc) begin
                           m_busy[0] = 0;
                           launch = m_tx[0][19];
                           m_ph = ob[1] ? 2 : 0;
                       end
                    2: if (acc) begin m_busy[1] = 0; m_ph = 0; end
                    default: if (acc) begin m_busy[2] = 0; m_ph = 0; end
                endcase
                for (int s = 0; s < 3; s++) begin
                    if (bus_wr && bus_addr == 3'(2 + s) && !ob[s]) begin
                        m_tx[s] = bus_wdata[19:0];
                        m_busy[s] = 1;
                    end
                    if (rx_valid && rx_slot == 2'(s) && c[3 + 2*s]) begin
                        m_rx[s] = rx_data; m_rxv[s] = 1; m_rxb[s] = 0;
                    end else if (bus_rd && bus_addr == 3'(5 + s)) begin
                        m_rxv[s] = 0;
                    end
                end
                if (launch && c[3]) m_rxb[0] = 1;
                if (launch && c[5]) m_rxb[1] = 1;
            end
        end
    end

    // every-cycle comparison against the model, mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            logic ev;
            logic [31:0] er;
            int sl;
            ev = (m_ph != 0) && m_ctrl[0];
            sl = (m_ph == 0) ? 0 : m_ph - 1;
            check("R8", "tx_valid", 32'(tx_valid), 32'(ev));
            if (ev) begin
                check("R8", "tx_slot", 32'(tx_slot), 32'(sl));
                check("R8", "tx_data", 32'(tx_data), 32'(m_tx[sl]));
            end
            check("R7", "tx_codec", 32'(tx_codec), 32'(m_ctrl[11:10]));
            if (bus_rd) begin
                case (bus_addr)
                    3'd0: er = 32'(m_ctrl);
                    3'd1: er = m_flags();
                    3'd2, 3'd3, 3'd4: er = 32'(m_tx[bus_addr - 3'd2]);
                    default: er = 32'(m_rx[bus_addr - 3'd5]);
                endcase
                check("R1", "model rdata", bus_rdata, er);
            end
            if (tx_valid && tx_ready) acc_q.push_back({tx_slot, tx_data});
        end
    end

    task automatic bw(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic brd(input logic [2:0] a, input logic [31:0] exp, input string req);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        check(req, "bus read", bus_rdata, exp);
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic rxsend(input logic [1:0] s, input logic [PAY_W-1:0] d);
        rx_valid = 1; rx_slot = s; rx_data = d;
        @(posedge clk); #1;
        rx_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic qchk(input string req, input int idx, input logic [1:0] s,
                        input logic [PAY_W-1:0] d);
        if (acc_q.size() > idx) check(req, "sent word", 32'(acc_q[idx]), 32'({s, d}));
        else check(req, "sent word count", 32'(acc_q.size()), 32'(idx + 1));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; errs++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, n_chk);
        $finish;
    end

    initial begin
        rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        rx_valid = 0; rx_slot = 0; rx_data = 0; tx_ready = 1;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1", "tx_valid after reset", 32'(tx_valid), 0);
        @(posedge clk); #1;
        brd(3'd1, 32'hA80, "R1");

        stall = 1;
        bw(3'd0, CTRL_ALL);
        check("R7", "codec select", 32'(tx_codec), 32'd1);

        // R2: register write as a linked pair, command first
        acc_q.delete();
        bw(3'd3, 32'hABCD0);
        bw(3'd2, 32'h2A000);
        idle(20);
        check("R2", "pair count", 32'(acc_q.size()), 2);
        qchk("R2", 0, 2'd0, 20'h2A000);
        qchk("R2", 1, 2'd1, 20'hABCD0);
        brd(3'd1, 32'hA80, "R4");

        // R3: read request goes out alone and arms the receive side
        acc_q.delete();
        bw(3'd2, 32'hFC000);
        idle(10);
        check("R3", "request count", 32'(acc_q.size()), 1);
        qchk("R3", 0, 2'd0, 20'hFC000);
        brd(3'd1, 32'hA85, "R3");
        rxsend(2'd0, 20'h7C000);
        rxsend(2'd1, 20'h12340);
        brd(3'd1, 32'hBC0, "R9");
        brd(3'd5, 32'h7C000, "R9");
        brd(3'd6, 32'h12340, "R9");
        brd(3'd1, 32'hA80, "R10");

        // R5: command TX enable low holds the slot
        acc_q.delete();
        bw(3'd0, 32'h5E9);
        bw(3'd2, 32'h11000);
        idle(15);
        check("R5", "held while disabled", 32'(acc_q.size()), 0);
        brd(3'd1, 32'hA02, "R4");
        // R6: a write into a busy slot is dropped
        bw(3'd2, 32'h22000);
        bw(3'd0, CTRL_ALL);
        idle(10);
        check("R6", "count", 32'(acc_q.size()), 1);
        qchk("R6", 0, 2'd0, 20'h11000);

        // R5: data TX enable low holds the whole pair
        acc_q.delete();
        bw(3'd0, 32'h5B9);
        bw(3'd3, 32'h55550);
        bw(3'd2, 32'h33000);
        idle(15);
        check("R5", "pair held", 32'(acc_q.size()), 0);
        bw(3'd0, CTRL_ALL);
        idle(15);
        qchk("R5", 0, 2'd0, 20'h33000);
        qchk("R5", 1, 2'd1, 20'h55550);

        // R7: codec number 4 blocks launches
        acc_q.delete();
        bw(3'd0, 32'h11F9);
        bw(3'd2, 32'h44000);
        idle(15);
        check("R7", "blocked count", 32'(acc_q.size()), 0);
        check("R7", "codec low bits", 32'(tx_codec), 0);
        bw(3'd0, CTRL_ALL);
        idle(10);
        qchk("R7", 0, 2'd0, 20'h44000);

        // R12: aux slot alone, then behind a ready command pair
        acc_q.delete();
        bw(3'd4, 32'h00FF0);
        idle(10);
        check("R12", "aux alone count", 32'(acc_q.size()), 1);
        qchk("R12", 0, 2'd2, 20'h00FF0);
        acc_q.delete();
        bw(3'd0, 32'h4E9);
        bw(3'd4, 32'hAAAA0);
        bw(3'd3, 32'h60600);
        bw(3'd2, 32'h66000);
        bw(3'd0, CTRL_ALL);
        idle(20);
        qchk("R12", 0, 2'd0, 20'h66000);
        qchk("R12", 1, 2'd1, 20'h60600);
        qchk("R12", 2, 2'd2, 20'hAAAA0);

        // R9: capture ignored with receive enable low
        bw(3'd0, 32'h5F1);
        rxsend(2'd0, 20'h99000);
        brd(3'd1, 32'hA80, "R9");
        brd(3'd5, 32'h7C000, "R9");
        bw(3'd0, CTRL_ALL);

        // R10: capture and read of the same register in one cycle
        bus_rd = 1; bus_addr = 3'd6;
        rx_valid = 1; rx_slot = 2'd1; rx_data = 20'h5A5A0;
        @(posedge clk); #1;
        bus_rd = 0; rx_valid = 0;
        brd(3'd1, 32'hB80, "R10");
        brd(3'd6, 32'h5A5A0, "R10");
        brd(3'd1, 32'hA80, "R10");

        // R11: interface off clears slot state and drops pending data
        rxsend(2'd0, 20'h0AB00);
        bw(3'd3, 32'h77770);
        bw(3'd0, 32'h5F8);
        idle(2);
        brd(3'd1, 32'hA80, "R11");
        brd(3'd5, 32'h0, "R11");
        brd(3'd3, 32'h0, "R11");
        brd(3'd0, 32'h5F8, "R11");
        acc_q.delete();
        bw(3'd0, CTRL_ALL);
        idle(10);
        check("R11", "nothing sent after re-enable", 32'(acc_q.size()), 0);

        stall = 0;
        idle(4);
        $display("Result: errors=%0d of %0d checks", errs, n_chk);
        $finish;
    end

endmodule